// File: doc/BRIEF.md
# PCIe Transceiver Reset Sequencer

This block drives the four reset lines of a serial transceiver channel running PCIe Gen1: the PLL analog reset, the transmit digital reset, the receive analog reset and the receive digital reset. It has two phases.

After power-up it runs the initialization and compliance phase. The PLL reset is held for a fixed number of cycles and then released. Transmit is released once the PLL reports lock. Both receive resets are released together once the reconfiguration busy flag has stayed low for two cycles. Receiver frequency lock plays no part in this phase. A completion strobe from the link layer then moves the block into the normal phase.

In the normal phase the block watches the frequency-lock flags of all bonded lanes. When any lane loses lock, the block waits until every lane has lock again. It then waits a settle delay and pulses the receive digital reset for exactly two cycles, which reinitializes the receive phase-compensation FIFO. If PLL lock is lost at any time after the PLL reset has been released, the whole sequence starts again. The lock and busy inputs are asynchronous and pass through two flip-flop stages. All outputs are registered.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low, all four resets are high and `link_ready` is low. After `rst_n` rises, `pll_rst` falls on the PLL_RST_CYC-th rising edge. `tx_rst`, `rx_ana_rst` and `rx_dig_rst` stay high for as long as `pll_rst` is high.
- R2: `tx_rst` stays high until PLL lock is seen after the PLL reset is released. It falls on the third rising edge after `pll_lock_in` rises, because of the two synchronizer stages and the registered output. If lock is already present when `pll_rst` falls, `tx_rst` falls one edge later.
- R3: `rx_ana_rst` stays high while the synchronized busy flag is high. The flag must then be seen low on two consecutive edges. If `busy_in` is already low, `rx_ana_rst` falls two edges after `tx_rst` falls. Otherwise it falls on the fourth edge after `busy_in` falls.
- R4: In the compliance phase, `rx_lock_in` has no effect. Any pattern on it leaves all resets released and `link_ready` low.
- R5: When leaving the initialization sequence, `rx_ana_rst` and `rx_dig_rst` fall on the same edge.
- R6: `compliance_done` is synchronous and not synchronized. When it is high on an edge in the compliance phase, `link_ready` rises on that edge.
- R7: In the normal phase, any lane of `rx_lock_in` going low drops `link_ready` on the third edge after the change. No reset is asserted while the block waits for lock to return.
- R8: Once every lane of `rx_lock_in` is high again, `rx_dig_rst` rises on edge 3+LTD_CYC after the last lane rises. It stays high for exactly two edges. It falls on the same edge that `link_ready` rises.
- R9: If any lane drops during the settle delay, the delay is abandoned and no pulse is issued. The full delay restarts only when all lanes are high again.
- R10: When `pll_lock_in` falls after the PLL reset has been released, all four resets are high and `link_ready` is low from the third edge after the fall. The sequence then restarts from R1 and returns to the compliance phase.
- R11: `link_ready` is high only in the normal-phase idle state, and only while all four resets are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_in | input | 1 | PLL lock indication (asynchronous) |
| busy_in | input | 1 | Reconfiguration busy flag (asynchronous) |
| rx_lock_in | input | LANES | Per-lane receiver frequency lock (asynchronous) |
| compliance_done | input | 1 | Link layer strobe: compliance phase completed |
| pll_rst | output | 1 | PLL analog reset |
| tx_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| link_ready | output | 1 | Normal-phase idle with all resets released |

## Verification
The bench builds the block with two bonded lanes, a five-cycle PLL reset and a four-cycle settle delay. These short counts let every edge of each timing window be counted directly. Two lanes are enough to sweep every loss pattern (either lane or both) and relock orders in which the lanes return one after the other. They also allow a lane to drop partway through the settle delay. Because the counts are small, the bench can also drop PLL lock in the normal phase and run the whole power-up sequence a second time.

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int LANES       = 4,
  parameter int PLL_RST_CYC = 125000000,
  parameter int LTD_CYC     = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_lock_in,
  input  logic             busy_in,
  input  logic [LANES-1:0] rx_lock_in,
  input  logic             compliance_done,
  output logic             pll_rst,
  output logic             tx_rst,
  output logic             rx_ana_rst,
  output logic             rx_dig_rst,
  output logic             link_ready
);
  localparam int CMAX = (PLL_RST_CYC > LTD_CYC) ? PLL_RST_CYC : LTD_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    ST_PLL, ST_LOCK, ST_TX, ST_CPL, ST_RUN, ST_LOST, ST_SETTLE, ST_PULSE
  } st_t;

  st_t state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [1:0] pll_sq, busy_sq;
  logic [LANES-1:0] lk1, lk2;

  wire pll_s  = pll_sq[1];
  wire busy_s = busy_sq[1];
  wire all_lk = &lk2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pll_sq  <= '0;
      busy_sq <= '0;
      lk1     <= '0;
      lk2     <= '0;
    end else begin
      pll_sq  <= {pll_sq[0], pll_lock_in};
      busy_sq <= {busy_sq[0], busy_in};
      lk1     <= rx_lock_in;
      lk2     <= lk1;
    end

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      ST_PLL:
        if (cnt == CW'(PLL_RST_CYC - 1)) begin
          state_n = ST_LOCK;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      ST_LOCK:
        if (pll_s) state_n = ST_TX;
      ST_TX:
        if (busy_s) cnt_n = '0;
        else if (cnt == CW'(1)) begin
          state_n = ST_CPL;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      ST_CPL:
        if (compliance_done) state_n = ST_RUN;
      ST_RUN:
        if (!all_lk) state_n = ST_LOST;
      ST_LOST:
        if (all_lk) begin
          state_n = ST_SETTLE;
          cnt_n   = '0;
        end
      ST_SETTLE:
        if (!all_lk) state_n = ST_LOST;
        else if (cnt == CW'(LTD_CYC - 1)) begin
          state_n = ST_PULSE;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      ST_PULSE:
        if (cnt == CW'(1)) begin
          state_n = ST_RUN;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      default: state_n = ST_PLL;
    endcase
    if (state != ST_PLL && state != ST_LOCK && !pll_s) begin
      state_n = ST_PLL;
      cnt_n   = '0;
    end
  end

  wire early = (state_n == ST_PLL) || (state_n == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_PLL;
      cnt        <= '0;
      pll_rst    <= 1'b1;
      tx_rst     <= 1'b1;
      rx_ana_rst <= 1'b1;
      rx_dig_rst <= 1'b1;
      link_ready <= 1'b0;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      pll_rst    <= state_n == ST_PLL;
      tx_rst     <= early;
      rx_ana_rst <= early || state_n == ST_TX;
      rx_dig_rst <= early || state_n == ST_TX || state_n == ST_PULSE;
      link_ready <= state_n == ST_RUN;
    end
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_lock_in,
  input logic pll_rst,
  input logic tx_rst,
  input logic rx_ana_rst,
  input logic rx_dig_rst,
  input logic link_ready
);
  AST_PLL_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> (tx_rst && rx_ana_rst && rx_dig_rst)); // R1
  AST_TX_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rst) |-> $past(pll_lock_in, 3)); // R2
  AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ana_rst |-> !tx_rst); // R3
  AST_RX_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ana_rst) |-> $fell(rx_dig_rst)); // R5
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_dig_rst) && !rx_ana_rst) |=> (rx_dig_rst || pll_rst)); // R8
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dig_rst && $past(rx_dig_rst) && !rx_ana_rst) |=> (!rx_dig_rst || rx_ana_rst)); // R8
  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> (!pll_rst && !tx_rst && !rx_ana_rst && !rx_dig_rst)); // R11
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock_in(pll_lock_in),
  .pll_rst(pll_rst), .tx_rst(tx_rst), .rx_ana_rst(rx_ana_rst),
  .rx_dig_rst(rx_dig_rst), .link_ready(link_ready)
);

// File: tb/xcvr_rst_seq_test.sv
`timescale 1ns/1ps
module xcvr_rst_seq_test;
  localparam int NL = 2, PRC = 5, LTD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pll_lock_in = 1'b0, busy_in = 1'b1, compliance_done = 1'b0;
  logic [NL-1:0] rx_lock_in = '0;
  logic pll_rst, tx_rst, rx_ana_rst, rx_dig_rst, link_ready;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  xcvr_rst_seq #(.LANES(NL), .PLL_RST_CYC(PRC), .LTD_CYC(LTD)) uut (
    .clk(clk), .rst_n(rst_n), .pll_lock_in(pll_lock_in), .busy_in(busy_in),
    .rx_lock_in(rx_lock_in), .compliance_done(compliance_done),
    .pll_rst(pll_rst), .tx_rst(tx_rst), .rx_ana_rst(rx_ana_rst),
    .rx_dig_rst(rx_dig_rst), .link_ready(link_ready));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return pll_rst;
      1: return tx_rst;
      2: return rx_ana_rst;
      3: return rx_dig_rst;
      default: return link_ready;
    endcase
  endfunction

  task automatic edges_until(input int sel, input logic val, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (sig(sel) != val && n < 60);
  endtask

  function automatic int outs();
    return {pll_rst, tx_rst, rx_ana_rst, rx_dig_rst, link_ready};
  endfunction

  task automatic power_up(input bit lock_early, input string tag);
    int n;
    edges_until(0, 1'b0, n);
    chk({tag, " R1 pll_rst length"}, n, PRC);
    if (lock_early) begin
      edges_until(1, 1'b0, n);
      chk({tag, " R2 tx release, lock early"}, n, 1);
      chk({tag, " R3 rx held while busy"}, rx_ana_rst, 1);
    end else begin
      for (int i = 0; i < 4; i++) step();
      chk({tag, " R2 tx held without lock"}, tx_rst, 1);
      pll_lock_in = 1'b1;
      edges_until(1, 1'b0, n);
      chk({tag, " R2 tx release after lock"}, n, 3);
    end
  endtask

  initial begin
    int n;
    #50;
    chk("R1 reset state", outs(), 5'b11110);
    step();
    rst_n = 1'b1;
    for (int i = 0; i < PRC - 1; i++) begin
      step();
      chk("R1 others held during pll reset", {tx_rst, rx_ana_rst, rx_dig_rst}, 3'b111);
    end
    edges_until(0, 1'b0, n);
    chk("R1 pll_rst falls on last edge", n, 1);
    for (int i = 0; i < 4; i++) step();
    chk("R2 tx held without lock", tx_rst, 1);
    pll_lock_in = 1'b1;
    edges_until(1, 1'b0, n);
    chk("R2 tx release after lock", n, 3);
    for (int i = 0; i < 5; i++) step();
    chk("R3 rx held while busy", rx_ana_rst, 1);
    busy_in = 1'b0;
    edges_until(2, 1'b0, n);
    chk("R3 rx release after busy low", n, 4);
    chk("R5 rx digital released with analog", rx_dig_rst, 0);
    for (int p = 0; p < 4; p++) begin
      rx_lock_in = NL'(p);
      for (int i = 0; i < 4; i++) step();
      chk($sformatf("R4 lane pattern %0d ignored", p), outs(), 5'b00000);
    end
    rx_lock_in = 2'b11;
    for (int i = 0; i < 4; i++) step();
    compliance_done = 1'b1;
    step();
    compliance_done = 1'b0;
    chk("R6 ready after compliance done", link_ready, 1);

    for (int p = 0; p < 3; p++) begin
      rx_lock_in = NL'(p);
      edges_until(4, 1'b0, n);
      chk($sformatf("R7 ready drop, loss pattern %0d", p), n, 3);
      for (int i = 0; i < 5; i++) begin
        step();
        chk($sformatf("R7 no reset while waiting, pattern %0d", p), outs(), 0);
      end
      if (p == 0) begin
        rx_lock_in = 2'b01;
        step();
        step();
      end
      rx_lock_in = 2'b11;
      edges_until(3, 1'b1, n);
      chk($sformatf("R8 pulse start, pattern %0d", p), n, 3 + LTD);
      chk($sformatf("R8 ready low in pulse, pattern %0d", p), link_ready, 0);
      step();
      chk($sformatf("R8 pulse second cycle, pattern %0d", p), rx_dig_rst, 1);
      step();
      chk($sformatf("R8 pulse end and ready, pattern %0d", p), {rx_dig_rst, link_ready}, 2'b01);
      for (int i = 0; i < 3; i++) step();
      chk($sformatf("R11 idle outputs, pattern %0d", p), outs(), 5'b00001);
    end

    rx_lock_in = 2'b00;
    edges_until(4, 1'b0, n);
    rx_lock_in = 2'b11;
    step();
    step();
    rx_lock_in = 2'b10;
    step();
    rx_lock_in = 2'b11;
    edges_until(3, 1'b1, n);
    chk("R9 settle restarts after lane drop", n, 3 + LTD);
    step();
    step();
    chk("R8 back to idle", outs(), 5'b00001);

    pll_lock_in = 1'b0;
    edges_until(0, 1'b1, n);
    chk("R10 pll lock loss delay", n, 3);
    chk("R10 all resets on loss", outs(), 5'b11110);
    pll_lock_in = 1'b1;
    edges_until(0, 1'b0, n);
    chk("R10 R1 pll_rst length on restart", n, PRC);
    edges_until(1, 1'b0, n);
    chk("R10 R2 tx release, lock present", n, 1);
    edges_until(2, 1'b0, n);
    chk("R10 R3 rx release, busy already low", n, 2);
    chk("R10 R5 both rx released", rx_dig_rst, 0);
    for (int i = 0; i < 4; i++) step();
    chk("R10 R11 back in compliance, not ready", link_ready, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule